// File: doc/BRIEF.md
# Byte/Word Switchable Read-Only Memory

This block is a synthesizable read-only memory whose contents are fixed at elaboration from a seed-driven formula. A mode input selects how it is read. With `word_mode` high, each address returns a 16-bit word. With `word_mode` low, the same storage is seen as twice as many 8-bit bytes. In that case the extra input `lsb_in` picks the low or the high half of the addressed word. At the pin level, `lsb_in` shares a pad with data bit 15: in byte mode that lane turns into an input, which is why its output enable drops.

Reads are modelled on a clock. An access starts when the effective address changes. For a configurable number of edges the old data is still shown. After that a fill pattern marks the window where the data is not valid, and then the new data appears once the access latency has elapsed.

The block drives no tri-state logic itself. It exposes a per-bit output-enable vector, so a pad wrapper can build the three-state pins. Standby and output disable only clear those enables.

Top module: `bytewide_rom`

## Requirements
- R1: When `word_mode` is 1, once the access completes, `q_out` equals the full 16-bit word stored at `word_addr`.
- R2: When `word_mode` is 0, once the access completes, `q_out[7:0]` is the selected byte and `q_out[15:8]` is 0. `lsb_in`=0 selects bits 7:0 of the word, and `lsb_in`=1 selects bits 15:8.
- R3: The word stored at index i is the low 16 bits of (i × 40503), XOR `SEED`.
- R4: `ce_n`=1 sampled at an edge makes `q_oe` all zero after that edge, whatever the other inputs are.
- R5: `ce_n`=0 together with `oe_n`=1 makes `q_oe` all zero after the edge.
- R6: With `ce_n` and `oe_n` both 0, `q_oe` becomes 16'hFFFF after the edge in word mode and 16'h00FF in byte mode.
- R7: The effective address is the tuple {mode, word address, byte select}, where the byte select is taken as 0 in word mode. Let E0 be the edge at which this tuple is first sampled different from the previous one. `q_out` keeps its previous value after edges E0 through E(`HOLD_CYC`).
- R8: After edges E(`HOLD_CYC`+1) through E(`LAT_CYC`−1), `q_out` equals `FILL`.
- R9: From edge E(`LAT_CYC`) on, `q_out` shows the new data, and it stays there while the effective address is unchanged.
- R10: In word mode, `lsb_in` has no effect: toggling it neither restarts the access nor changes `q_out`.
- R11: In byte mode, a change of `lsb_in` alone is an address change, and so is a change of `word_mode` alone.
- R12: Synchronous reset clears `q_out` and `q_oe` to 0. The reset edge counts as E0 of an access to byte-mode address 0, low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes |
| word_addr | input | ADDR_W | Word address |
| lsb_in | input | 1 | Byte select in byte mode; ignored in word mode |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| q_out | output | 16 | Registered read data |
| q_oe | output | 16 | Per-bit output enable for the pad wrapper |

## Verification
The data path and the enable path are independent, so an address change and an enable change can land on the same edge. Examples are a mode switch together with `ce_n` falling, or a new byte select while `oe_n` rises. The random phase provokes this by redrawing address, mode, byte select and both enables together, and holding them for one to six cycles. A bench reference model then judges `q_out` and `q_oe` separately every cycle, against the hold, fill and data windows and against the lane mask of the mode in force.

// File: rtl/brom_pkg.sv
package brom_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  // Fixed contents: low half of index times an odd constant, mixed with a seed
  function automatic logic [WORD_W-1:0] brom_content(input int unsigned idx,
                                                     input logic [WORD_W-1:0] seed);
    logic [31:0] prod;
    prod = idx * 32'd40503;
    return prod[WORD_W-1:0] ^ seed;
  endfunction
endpackage

// File: rtl/brom_track.sv
module brom_track #(
  parameter int ADDR_W   = 10,
  parameter int LAT_CYC  = 3,
  parameter int HOLD_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              lsb_in,
  output logic              cur_wide,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_sel,
  output logic              change,
  output logic              sel_keep,
  output logic              sel_fill
);
  localparam int KEY_W = ADDR_W + 2;
  localparam int AGE_W = (LAT_CYC > 2) ? $clog2(LAT_CYC) : 1;
  localparam logic [AGE_W-1:0] AGE_TOP  = AGE_W'(LAT_CYC - 1);
  localparam logic [AGE_W:0]   HOLD_V   = (AGE_W+1)'(HOLD_CYC);
  localparam logic [AGE_W:0]   LAT_V    = (AGE_W+1)'(LAT_CYC);

  logic [KEY_W-1:0] key_in, key_q;
  logic [AGE_W-1:0] age;
  logic [AGE_W:0]   nxt;

  // byte select only takes part in the key when bytes are being read
  assign key_in = {word_mode, word_addr, (word_mode ? 1'b0 : lsb_in)};
  assign change = (key_in != key_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
      age   <= '0;
    end else if (change) begin
      key_q <= key_in;
      age   <= '0;
    end else if (age != AGE_TOP) begin
      age <= age + 1'b1;
    end
  end

  assign nxt      = {1'b0, age} + 1'b1;
  assign sel_keep = change || (nxt <= HOLD_V);
  assign sel_fill = !sel_keep && (nxt < LAT_V);

  assign cur_wide = key_q[KEY_W-1];
  assign cur_addr = key_q[KEY_W-2:1];
  assign cur_sel  = key_q[0];

  p_age_bound_r9: assert property (@(posedge clk) disable iff (rst)
    age <= AGE_TOP);
endmodule

// File: rtl/brom_array.sv
module brom_array
  import brom_pkg::*;
#(
  parameter int              ADDR_W = 10,
  parameter logic [WORD_W-1:0] SEED = 16'h5A3C
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = brom_content(i, SEED);
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/brom_drive.sv
module brom_drive
  import brom_pkg::*;
#(
  parameter logic [WORD_W-1:0] FILL = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_keep,
  input  logic              sel_fill,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              cur_wide,
  input  logic              cur_sel,
  input  logic              word_mode,
  input  logic              ce_n,
  input  logic              oe_n,
  output logic [WORD_W-1:0] q_out,
  output logic [WORD_W-1:0] q_oe
);
  localparam logic [WORD_W-1:0] LOW_LANES = {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [BYTE_W-1:0] pick;
  assign pick = cur_sel ? rd_data[WORD_W-1:BYTE_W] : rd_data[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      q_out <= '0;
    end else if (sel_keep) begin
      q_out <= q_out;
    end else if (sel_fill) begin
      q_out <= FILL;
    end else begin
      q_out <= cur_wide ? rd_data : {{(WORD_W-BYTE_W){1'b0}}, pick};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  q_oe <= '0;
    else if (!ce_n && !oe_n)  q_oe <= word_mode ? '1 : LOW_LANES;
    else                      q_oe <= '0;
  end

  p_fill_r8: assert property (@(posedge clk) disable iff (rst)
    sel_fill |=> (q_out == FILL));
endmodule

// File: rtl/bytewide_rom.sv
module bytewide_rom
  import brom_pkg::*;
#(
  parameter int                ADDR_W   = 10,
  parameter int                LAT_CYC  = 3,
  parameter int                HOLD_CYC = 1,
  parameter logic [WORD_W-1:0] FILL     = 16'hDEAD,
  parameter logic [WORD_W-1:0] SEED     = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              lsb_in,
  input  logic              ce_n,
  input  logic              oe_n,
  output logic [15:0]       q_out,
  output logic [15:0]       q_oe
);
  logic              cur_wide, cur_sel, change, sel_keep, sel_fill;
  logic [ADDR_W-1:0] cur_addr;
  logic [15:0]       rd_data;

  brom_track #(.ADDR_W(ADDR_W), .LAT_CYC(LAT_CYC), .HOLD_CYC(HOLD_CYC)) u_track (
    .clk(clk), .rst(rst), .word_mode(word_mode), .word_addr(word_addr),
    .lsb_in(lsb_in), .cur_wide(cur_wide), .cur_addr(cur_addr),
    .cur_sel(cur_sel), .change(change), .sel_keep(sel_keep),
    .sel_fill(sel_fill));

  brom_array #(.ADDR_W(ADDR_W), .SEED(SEED)) u_array (
    .clk(clk), .rd_addr(cur_addr), .rd_data(rd_data));

  brom_drive #(.FILL(FILL)) u_drive (
    .clk(clk), .rst(rst), .sel_keep(sel_keep), .sel_fill(sel_fill),
    .rd_data(rd_data), .cur_wide(cur_wide), .cur_sel(cur_sel),
    .word_mode(word_mode), .ce_n(ce_n), .oe_n(oe_n),
    .q_out(q_out), .q_oe(q_oe));

  p_standby_r4: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (q_oe == '0));
  p_outoff_r5: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && oe_n) |=> (q_oe == '0));
  p_bytelanes_r6: assert property (@(posedge clk) disable iff (rst)
    !word_mode |=> (q_oe[15:8] == '0));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    change |=> $stable(q_out));
endmodule

// File: tb/sim_bytewide_rom.sv
module sim_bytewide_rom;
  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 10;
  localparam int          LAT_CYC    = 3;
  localparam int          HOLD_CYC   = 1;
  localparam logic [15:0] FILL       = 16'hDEAD;
  localparam logic [15:0] SEED       = 16'h5A3C;

  logic              clk = 0, rst = 1;
  logic              word_mode = 1, lsb_in = 0, ce_n = 1, oe_n = 1;
  logic [ADDR_W-1:0] word_addr = '0;
  logic [15:0]       q_out, q_oe;

  int checks = 0, failures = 0;
  string section = "reset";

  // reference state
  logic              m_wide, m_sel;
  logic [ADDR_W-1:0] m_addr;
  int                m_since;
  logic [15:0]       m_dout, m_oe;
  string             m_tag;

  bytewide_rom #(.ADDR_W(ADDR_W), .LAT_CYC(LAT_CYC), .HOLD_CYC(HOLD_CYC),
                 .FILL(FILL), .SEED(SEED)) u0 (
    .clk(clk), .rst(rst), .word_mode(word_mode), .word_addr(word_addr),
    .lsb_in(lsb_in), .ce_n(ce_n), .oe_n(oe_n), .q_out(q_out), .q_oe(q_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ref_word(input int unsigned a);
    logic [31:0] p;
    p = a * 32'd40503;
    return p[15:0] ^ SEED;
  endfunction

  function automatic logic [15:0] ref_read(input logic wide, input logic [ADDR_W-1:0] a,
                                           input logic sel);
    logic [15:0] w;
    w = ref_word(a);
    if (wide) return w;
    return sel ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic model_edge();
    logic s;
    s = word_mode ? 1'b0 : lsb_in;
    if (rst) begin
      m_wide = 0; m_addr = '0; m_sel = 0; m_since = 0;
      m_dout = '0; m_oe = '0; m_tag = "R12";
      return;
    end
    if (word_mode != m_wide || word_addr != m_addr || s != m_sel) begin
      m_wide = word_mode; m_addr = word_addr; m_sel = s; m_since = 0;
      m_tag = "R7";
    end else begin
      m_since++;
      if (m_since <= HOLD_CYC) m_tag = "R7";
      else if (m_since < LAT_CYC) begin m_dout = FILL; m_tag = "R8"; end
      else begin
        m_dout = ref_read(m_wide, m_addr, m_sel);
        m_tag = m_wide ? "R1/R3/R9" : "R2/R3/R9";
      end
    end
    if (ce_n) m_oe = '0;
    else if (oe_n) m_oe = '0;
    else m_oe = word_mode ? 16'hFFFF : 16'h00FF;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s [%s] actual=%h expected=%h", req, section, act, exp);
    end
  endtask

  task automatic tick();
    logic oe_ce, oe_oe;
    oe_ce = ce_n; oe_oe = oe_n;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(m_tag, q_out, m_dout);
    check(oe_ce ? "R4" : (oe_oe ? "R5" : "R6"), q_oe, m_oe);
  endtask

  task automatic set_in(input logic wm, input int unsigned a, input logic sel,
                        input logic ce, input logic oe);
    word_mode = wm; word_addr = ADDR_W'(a); lsb_in = sel; ce_n = ce; oe_n = oe;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired checks=%0d", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    section = "R12 reset";
    set_in(0, 0, 0, 1, 1);
    tick(); tick();
    rst = 0;
    // reset edge is E0 of byte addr 0 low: R12 then fill then data
    for (int i = 0; i < 4; i++) tick();

    section = "R1 word read";
    set_in(1, 37, 0, 0, 0);
    for (int i = 0; i < 5; i++) tick();

    section = "R10 word mode ignores lsb";
    lsb_in = 1; tick();
    lsb_in = 0; tick();
    lsb_in = 1; tick(); tick();

    section = "R2 byte low then R11 high";
    set_in(0, 37, 0, 0, 0);
    for (int i = 0; i < 4; i++) tick();
    lsb_in = 1;
    for (int i = 0; i < 4; i++) tick();

    section = "R11 mode switch only";
    word_mode = 1;
    for (int i = 0; i < 4; i++) tick();

    section = "R4 standby";
    ce_n = 1; oe_n = 0; tick(); tick();
    section = "R5 output disabled";
    ce_n = 0; oe_n = 1; tick(); tick();

    section = "R2 top address";
    set_in(0, (1 << ADDR_W) - 1, 1, 0, 0);
    for (int i = 0; i < 4; i++) tick();

    section = "R7 interrupted access";
    set_in(1, 5, 0, 0, 0); tick(); tick();
    set_in(1, 6, 0, 0, 0);
    for (int i = 0; i < 4; i++) tick();

    section = "random R6 R7 R8 R9";
    for (int n = 0; n < 400; n++) begin
      int unsigned hold;
      set_in($urandom_range(0, 1), $urandom_range(0, (1 << ADDR_W) - 1),
             $urandom_range(0, 1), ($urandom_range(0, 5) == 0),
             ($urandom_range(0, 5) == 0));
      hold = $urandom_range(1, 6);
      for (int k = 0; k < int'(hold); k++) tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule